// File: doc/BRIEF.md
# Atomic Read-Modify-Write Line Lock Controller

This block sits beside one core in a small group of cores whose caches stay coherent by watching a shared snoop bus. It carries out one atomic operation at a time on a single cached line: fetch-and-add, exchange, compare-and-swap, or a plain read. Before it starts, it waits until every older load and store from its core has finished. It then gains sole ownership of the line, locking it until the new value is written back.

The controller keeps its own copy of one line, with a tag, a MESI state and one data word. If that copy is not already held Exclusive or Modified, the controller asks the bus for ownership and loads the word that comes back with the grant. Snoops from other cores are answered from this copy, and every snoop that is acknowledged and hits the line invalidates it. A snoop that hits the line while it is locked gets no acknowledge until the write-back has finished. Without this stall, another core could slip a store in between the read and the write, and that store would be lost.

The sequence is driven by a state machine with six states. IDLE accepts a request. DRAIN waits for older accesses to finish. ACQUIRE holds the lock and obtains ownership. MODIFY computes the result. WRITEBACK stores the value into the line. RELEASE drops the lock and reports the result. The transitions are: IDLE to DRAIN when a request arrives, DRAIN to ACQUIRE once nothing older is pending, ACQUIRE to MODIFY when the line is owned or the bus grants it, and then MODIFY to WRITEBACK, WRITEBACK to RELEASE and RELEASE back to IDLE, one cycle each.

Top module: `atomic_line_lock_ctrl`

## Requirements
- R1: After reset the controller is idle: `req_ready`=1, `rsp_done`=0, `bus_req`=0, and the line is Invalid, so a snoop is acknowledged at once with `snp_hit`=0.
- R2: While `older_pending` is high after a request has been accepted, the controller raises neither `bus_req` nor `rsp_done`. The operation resumes once `older_pending` falls.
- R3: If the line is not held Exclusive or Modified under the requested line address, `bus_req` stays high with `bus_line` equal to that address until `bus_gnt`. The `bus_rdata` word present with the grant becomes the line's current value, and the line becomes Exclusive.
- R4: If the line is already held Exclusive or Modified under that address, no bus request is made. With `older_pending` low, `rsp_done` is high in the cycle that follows the fourth clock edge after the accepting edge.
- R5: Fetch-and-add (`req_op`=0) returns the old value and leaves old+`req_arg` modulo 2^DW in the line, which becomes Modified.
- R6: Exchange (`req_op`=1) returns the old value and leaves `req_arg` in the line, which becomes Modified.
- R7: Compare-and-swap (`req_op`=2) writes `req_arg` and sets `rsp_cas_ok`=1 only when the old value equals `req_cmp`. Otherwise it leaves the line unchanged and Exclusive and returns `rsp_cas_ok`=0. In both cases it returns the old value.
- R8: Plain read (`req_op`=3) returns the old value and leaves the line's data and state unchanged. `rsp_cas_ok` is 0 for every opcode other than 2.
- R9: A snoop whose address matches the owned line gets `snp_ack`=0 through ACQUIRE, MODIFY and WRITEBACK. In RELEASE it is acknowledged and returns the new value with `snp_dirty`=1.
- R10: A snoop whose address does not match the line is acknowledged in the same cycle with `snp_hit`=0, even while an operation holds the lock.
- R11: An acknowledged snoop that hits returns `snp_hit`=1, `snp_dirty` equal to whether the line is Modified, and the line data in `snp_data`. The line then becomes Invalid, so the next operation on it must request the bus.
- R12: `rsp_done` is a single-cycle pulse. `req_ready` is low from the accepting edge until the controller is back in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Atomic request strobe, accepted in IDLE |
| req_ready | output | 1 | Controller is idle and able to accept a request |
| req_op | input | 2 | 0 fetch-add, 1 exchange, 2 compare-and-swap, 3 read |
| req_line | input | LAW | Line address of the operand |
| req_arg | input | DW | Addend, or the new value for exchange and compare-and-swap |
| req_cmp | input | DW | Expected value for compare-and-swap |
| older_pending | input | 1 | High while older loads or stores from the core are still outstanding |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_old | output | DW | Value of the line before the operation, valid with done |
| rsp_cas_ok | output | 1 | Compare-and-swap success, valid with done |
| bus_req | output | 1 | Request for ownership of the line |
| bus_line | output | LAW | Line address carried with the ownership request |
| bus_gnt | input | 1 | Ownership granted, with the line data |
| bus_rdata | input | DW | Line data delivered with the grant |
| snp_valid | input | 1 | Snoop from another core, held until acknowledged |
| snp_line | input | LAW | Snooped line address |
| snp_ack | output | 1 | Snoop answered in this cycle |
| snp_hit | output | 1 | This cache holds the snooped line |
| snp_dirty | output | 1 | The held line is Modified |
| snp_data | output | DW | Line data returned with a hit |

## Verification
When the line is owned and nothing older is pending, the completion pulse and result are due in the cycle after the fourth clock edge that follows acceptance. Waiting for a grant adds one cycle for each cycle that `bus_req` stays high without `bus_gnt`. The bench drives inputs on falling edges and samples on falling edges. It counts those edges from the request to the first sight of done, and it checks that count against five both for an owned line and for a grant given on first sight of `bus_req`. Snoop acknowledges are combinational from the state, so the bench samples them shortly after the falling edge in each locked state, while the snoop is held. It checks the line contents by snooping after each operation. This reads out data, dirty flag and hit, and also invalidates the line for the next vector.

// File: rtl/atom_pkg.sv
package atom_pkg;

    typedef enum logic [1:0] {
        OP_FADD = 2'd0,
        OP_XCHG = 2'd1,
        OP_CAS  = 2'd2,
        OP_READ = 2'd3
    } atom_op_e;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_E = 2'd2,
        LN_M = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DRAIN     = 3'd1,
        ST_ACQUIRE   = 3'd2,
        ST_MODIFY    = 3'd3,
        ST_WRITEBACK = 3'd4,
        ST_RELEASE   = 3'd5
    } fsm_e;

endpackage

// File: rtl/atom_alu.sv
module atom_alu
    import atom_pkg::*;
#(
    parameter int DW = 32
) (
    input  atom_op_e        op,
    input  logic [DW-1:0]   cur,
    input  logic [DW-1:0]   arg,
    input  logic [DW-1:0]   cmp,
    output logic [DW-1:0]   nxt,
    output logic            wr,
    output logic            cas_ok
);

    always_comb begin
        nxt    = cur;
        wr     = 1'b0;
        cas_ok = 1'b0;
        unique case (op)
            OP_FADD: begin
                nxt = cur + arg;
                wr  = 1'b1;
            end
            OP_XCHG: begin
                nxt = arg;
                wr  = 1'b1;
            end
            OP_CAS: begin
                cas_ok = (cur == cmp);
                wr     = cas_ok;
                nxt    = cas_ok ? arg : cur;
            end
            OP_READ: begin
                nxt = cur;
            end
        endcase
    end

endmodule

// File: rtl/atom_line.sv
module atom_line
    import atom_pkg::*;
#(
    parameter int LAW = 12,
    parameter int DW  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fill_en,
    input  logic [LAW-1:0]  fill_tag,
    input  logic [DW-1:0]   fill_data,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            snp_inv,
    input  logic            lock,
    input  logic [LAW-1:0]  look_tag,
    input  logic [LAW-1:0]  snp_tag,
    output logic            owned,
    output logic            snp_match,
    output logic            is_dirty,
    output logic [DW-1:0]   data
);

    line_st_e       st_q;
    logic [LAW-1:0] tag_q;
    logic [DW-1:0]  data_q;

    // FSM fill/write take priority over a snoop invalidation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LN_I;
            tag_q  <= '0;
            data_q <= '0;
        end else if (fill_en) begin
            st_q   <= LN_E;
            tag_q  <= fill_tag;
            data_q <= fill_data;
        end else if (wr_en) begin
            st_q   <= LN_M;
            data_q <= wr_data;
        end else if (snp_inv) begin
            st_q   <= LN_I;
        end
    end

    assign owned     = ((st_q == LN_E) || (st_q == LN_M)) && (tag_q == look_tag);
    assign snp_match = (st_q != LN_I) && (tag_q == snp_tag);
    assign is_dirty  = (st_q == LN_M);
    assign data      = data_q;

    // R9: an owned line cannot be taken away while the lock is held
    p_locked_line_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && owned) |=> (st_q != LN_I));

endmodule

// File: rtl/atomic_line_lock_ctrl.sv
module atomic_line_lock_ctrl
    import atom_pkg::*;
#(
    parameter int LAW = 12,
    parameter int DW  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_op,
    input  logic [LAW-1:0]  req_line,
    input  logic [DW-1:0]   req_arg,
    input  logic [DW-1:0]   req_cmp,
    input  logic            older_pending,
    output logic            rsp_done,
    output logic [DW-1:0]   rsp_old,
    output logic            rsp_cas_ok,
    output logic            bus_req,
    output logic [LAW-1:0]  bus_line,
    input  logic            bus_gnt,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            snp_valid,
    input  logic [LAW-1:0]  snp_line,
    output logic            snp_ack,
    output logic            snp_hit,
    output logic            snp_dirty,
    output logic [DW-1:0]   snp_data
);

    fsm_e           st_q, st_d;
    atom_op_e       op_q;
    logic [LAW-1:0] line_q;
    logic [DW-1:0]  arg_q, cmp_q, old_q, new_q;
    logic           wr_q, ok_q;

    logic           owned, match, dirty, locked, fill_en, wb_en, inv_en;
    logic [DW-1:0]  cur_data, alu_new;
    logic           alu_wr, alu_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (req_valid)                st_d = ST_DRAIN;
            ST_DRAIN:     if (!older_pending)           st_d = ST_ACQUIRE;
            ST_ACQUIRE:   if (owned || bus_gnt)         st_d = ST_MODIFY;
            ST_MODIFY:                                  st_d = ST_WRITEBACK;
            ST_WRITEBACK:                               st_d = ST_RELEASE;
            ST_RELEASE:                                 st_d = ST_IDLE;
            default:                                    st_d = ST_IDLE;
        endcase
    end

    // request and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_READ;
            line_q <= '0;
            arg_q  <= '0;
            cmp_q  <= '0;
            old_q  <= '0;
            new_q  <= '0;
            wr_q   <= 1'b0;
            ok_q   <= 1'b0;
        end else if (st_q == ST_IDLE && req_valid) begin
            op_q   <= atom_op_e'(req_op);
            line_q <= req_line;
            arg_q  <= req_arg;
            cmp_q  <= req_cmp;
        end else if (st_q == ST_MODIFY) begin
            old_q  <= cur_data;
            new_q  <= alu_new;
            wr_q   <= alu_wr;
            ok_q   <= alu_ok;
        end
    end

    // outputs
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        rsp_done  = (st_q == ST_RELEASE);
        locked    = (st_q == ST_ACQUIRE) || (st_q == ST_MODIFY) || (st_q == ST_WRITEBACK);
        bus_req   = (st_q == ST_ACQUIRE) && !owned;
        bus_line  = line_q;
        fill_en   = bus_req && bus_gnt;
        wb_en     = (st_q == ST_WRITEBACK) && wr_q;
        snp_ack   = snp_valid && !(locked && match);
        snp_hit   = match;
        snp_dirty = match && dirty;
        snp_data  = cur_data;
        inv_en    = snp_ack && match;
    end

    assign rsp_old    = old_q;
    assign rsp_cas_ok = ok_q;

    atom_alu #(.DW(DW)) i_alu (
        .op     (op_q),
        .cur    (cur_data),
        .arg    (arg_q),
        .cmp    (cmp_q),
        .nxt    (alu_new),
        .wr     (alu_wr),
        .cas_ok (alu_ok)
    );

    atom_line #(.LAW(LAW), .DW(DW)) i_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .fill_tag  (line_q),
        .fill_data (bus_rdata),
        .wr_en     (wb_en),
        .wr_data   (new_q),
        .snp_inv   (inv_en),
        .lock      (locked),
        .look_tag  (line_q),
        .snp_tag   (snp_line),
        .owned     (owned),
        .snp_match (match),
        .is_dirty  (dirty),
        .data      (cur_data)
    );

    // R2: ownership is requested only after older accesses have drained
    p_drained_before_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !$past(older_pending));

    // R3: an ungranted request holds with a steady address
    p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_line)));

    // R12: completion is a single-cycle pulse
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R12: no new request is taken while a result is reported
    p_ready_low_on_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

    // R9: a stalled snoop never overlaps the release of the lock
    p_stall_not_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_ack) |-> !rsp_done);

endmodule

// File: tb/test_atomic_line_lock_ctrl.sv
module test_atomic_line_lock_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LAW = 12;
    localparam int DW  = 32;
    localparam int NVEC = 6;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] arg;
        logic [31:0] cmp;
        logic [31:0] fill;
        logic [31:0] old;
        logic [31:0] nw;
        logic        ok;
        logic        dirty;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 32'h0000_0005, 32'h0,         32'h0000_000A, 32'h0000_000A, 32'h0000_000F, 1'b0, 1'b1}, // R5
        '{2'd0, 32'h0000_0002, 32'h0,         32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1}, // R5 wrap
        '{2'd1, 32'h0000_A5A5, 32'h0,         32'h0000_1234, 32'h0000_1234, 32'h0000_A5A5, 1'b0, 1'b1}, // R6
        '{2'd2, 32'h0000_0099, 32'h0000_0077, 32'h0000_0077, 32'h0000_0077, 32'h0000_0099, 1'b1, 1'b1}, // R7 hit
        '{2'd2, 32'h0000_0099, 32'h0000_0076, 32'h0000_0077, 32'h0000_0077, 32'h0000_0077, 1'b0, 1'b0}, // R7 miss
        '{2'd3, 32'h0000_1111, 32'h0,         32'h0000_CAFE, 32'h0000_CAFE, 32'h0000_CAFE, 1'b0, 1'b0}  // R8
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [1:0]      req_op = '0;
    logic [LAW-1:0]  req_line = '0;
    logic [DW-1:0]   req_arg = '0;
    logic [DW-1:0]   req_cmp = '0;
    logic            older_pending = 1'b0;
    logic            rsp_done;
    logic [DW-1:0]   rsp_old;
    logic            rsp_cas_ok;
    logic            bus_req;
    logic [LAW-1:0]  bus_line;
    logic            bus_gnt = 1'b0;
    logic [DW-1:0]   bus_rdata = '0;
    logic            snp_valid = 1'b0;
    logic [LAW-1:0]  snp_line = '0;
    logic            snp_ack, snp_hit, snp_dirty;
    logic [DW-1:0]   snp_data;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atomic_line_lock_ctrl #(.LAW(LAW), .DW(DW)) i_atomic_line_lock_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_line(req_line), .req_arg(req_arg), .req_cmp(req_cmp),
        .older_pending(older_pending),
        .rsp_done(rsp_done), .rsp_old(rsp_old), .rsp_cas_ok(rsp_cas_ok),
        .bus_req(bus_req), .bus_line(bus_line), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_line(snp_line), .snp_ack(snp_ack),
        .snp_hit(snp_hit), .snp_dirty(snp_dirty), .snp_data(snp_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one request, grant on first sight of bus_req, return on done
    task automatic run_op(input logic [1:0] op, input logic [LAW-1:0] ln,
                          input logic [31:0] arg, input logic [31:0] cmp, input logic [31:0] fill,
                          output logic [31:0] old, output logic ok, output int lat,
                          output bit used_bus, output logic [LAW-1:0] seen_line);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_line = ln; req_arg = arg; req_cmp = cmp;
        used_bus = 1'b0; seen_line = '0;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 200) begin
            if (bus_req) begin
                used_bus = 1'b1; seen_line = bus_line;
                bus_gnt = 1'b1; bus_rdata = fill;
            end
            @(negedge clk);
            bus_gnt = 1'b0;
            lat++;
        end
        old = rsp_old;
        ok  = rsp_cas_ok;
    endtask

    task automatic do_snoop(input logic [LAW-1:0] ln, output logic hit,
                            output logic dirty, output logic [31:0] data);
        @(negedge clk);
        snp_valid = 1'b1; snp_line = ln;
        #1;
        for (int k = 0; k < 50 && !snp_ack; k++) begin
            @(negedge clk);
            #1;
        end
        hit = snp_hit; dirty = snp_dirty; data = snp_data;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] old, d;
        logic        ok, h, dy;
        int          lat;
        bit          ub;
        logic [LAW-1:0] bl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", {31'b0, req_ready}, 32'd1);
        chk("R1 done", {31'b0, rsp_done}, 32'd0);
        chk("R1 bus_req", {31'b0, bus_req}, 32'd0);
        snp_valid = 1'b1; snp_line = 12'h010; #1;
        chk("R1 snoop ack after reset", {31'b0, snp_ack}, 32'd1);
        chk("R1 snoop miss after reset", {31'b0, snp_hit}, 32'd0);
        @(negedge clk); snp_valid = 1'b0;

        // table of vectors: R3 R5 R6 R7 R8 R11
        for (int i = 0; i < NVEC; i++) begin
            run_op(VEC[i].op, LAW'(12'h040 + i), VEC[i].arg, VEC[i].cmp, VEC[i].fill, old, ok, lat, ub, bl);
            chk("R3 bus requested for unowned line", {31'b0, ub}, 32'd1);
            chk("R3 bus_line", {20'b0, bl}, 32'(12'h040 + i));
            chk("R5/R6/R7/R8 old value", old, VEC[i].old);
            chk("R7/R8 cas_ok", {31'b0, ok}, {31'b0, VEC[i].ok});
            do_snoop(LAW'(12'h040 + i), h, dy, d);
            chk("R11 snoop hit", {31'b0, h}, 32'd1);
            chk("R5/R6/R7/R8 line value", d, VEC[i].nw);
            chk("R11 dirty", {31'b0, dy}, {31'b0, VEC[i].dirty});
        end

        // R2 drain: request waits while older accesses are pending
        older_pending = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_line = 12'h200; req_arg = 32'h10;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 ready low while busy", {31'b0, req_ready}, 32'd0);
        for (int k = 0; k < 6; k++) begin
            chk("R2 no bus_req while draining", {31'b0, bus_req}, 32'd0);
            chk("R2 no done while draining", {31'b0, rsp_done}, 32'd0);
            @(negedge clk);
        end
        older_pending = 1'b0;
        lat = 0;
        while (!rsp_done && lat < 50) begin
            if (bus_req) begin bus_gnt = 1'b1; bus_rdata = 32'h100; end
            @(negedge clk);
            bus_gnt = 1'b0;
            lat++;
        end
        chk("R2 resumes after drain", {31'b0, rsp_done}, 32'd1);
        chk("R5 old after drain", rsp_old, 32'h100);

        // R4 owned line: no bus, fixed latency
        run_op(2'd0, 12'h200, 32'h1, 32'h0, 32'hDEAD, old, ok, lat, ub, bl);
        chk("R4 no bus for owned line", {31'b0, ub}, 32'd0);
        chk("R4 latency", lat, 32'd5);
        chk("R4 old value", old, 32'h110);
        @(negedge clk);
        chk("R12 done single pulse", {31'b0, rsp_done}, 32'd0);

        // R9 locked snoop stall
        req_valid = 1'b1; req_op = 2'd0; req_line = 12'h200; req_arg = 32'h2;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        snp_valid = 1'b1; snp_line = 12'h200; #1;
        chk("R9 stall in acquire", {31'b0, snp_ack}, 32'd0);
        @(negedge clk); #1;
        chk("R9 stall in modify", {31'b0, snp_ack}, 32'd0);
        @(negedge clk); #1;
        chk("R9 stall in writeback", {31'b0, snp_ack}, 32'd0);
        @(negedge clk); #1;
        chk("R9 ack at release", {31'b0, snp_ack}, 32'd1);
        chk("R9 done with release", {31'b0, rsp_done}, 32'd1);
        chk("R9 new data", snp_data, 32'h113);
        chk("R9 dirty", {31'b0, snp_dirty}, 32'd1);
        @(negedge clk);
        snp_valid = 1'b0;
        chk("R12 done dropped", {31'b0, rsp_done}, 32'd0);
        chk("R12 ready back", {31'b0, req_ready}, 32'd1);

        // R11 line invalidated by that snoop: bus needed again
        run_op(2'd3, 12'h200, 32'h0, 32'h0, 32'h55, old, ok, lat, ub, bl);
        chk("R11 bus after invalidation", {31'b0, ub}, 32'd1);
        chk("R11 refilled value", old, 32'h55);

        // R10 snoop miss answered while locked
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_line = 12'h200; req_arg = 32'h77;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        snp_valid = 1'b1; snp_line = 12'h201; #1;
        chk("R10 miss ack during lock", {31'b0, snp_ack}, 32'd1);
        chk("R10 miss no hit", {31'b0, snp_hit}, 32'd0);
        @(negedge clk);
        snp_valid = 1'b0;
        lat = 0;
        while (!rsp_done && lat < 50) begin @(negedge clk); lat++; end
        chk("R6 old value after miss snoop", rsp_old, 32'h55);
        do_snoop(12'h200, h, dy, d);
        chk("R6 exchanged value", d, 32'h77);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule